// File: doc/BRIEF.md
# NAND Flash Single-Register Bridge

This block connects a host bus to a raw 8-bit NAND flash device through a single 32-bit register. The host treats it as a 32-bit big-endian word. Any byte-lane swapping happens upstream, and bit numbers below count from the most significant bit 31. Each write to the register carries three fields: an operation code, a chip-enable flag and a data byte. The block turns that write into one of the following:

- a command-latch cycle on the flash pins,
- an address-latch cycle,
- a data-write cycle,
- or a switch into read mode.

Once read mode is selected, every host read of the register runs exactly one flash read strobe. The read returns the captured byte together with the flash busy flag. Reads made outside read mode return only the busy flag and do not touch the flash bus.

The host holds `host_req` until the block raises `host_ack` for one cycle. An access that needs a flash cycle is held off until its whole strobe sequence has finished. Strobe widths and recovery times are clock counts set by parameters.

Top module: `nand_reg_bridge`

## Requirements
- R1: The operation code sits in write-data bits 30:28. Code 0 is a command cycle, with CLE high and ALE low. Code 1 is an address cycle, with ALE high and CLE low. Code 3 is a data-write cycle, with both low. CLE and ALE are never high together.
- R2: `nand_ce_n` is low exactly while the most recently accepted register write had bit 31 set. Reads leave it unchanged.
- R3: For codes 0, 1 and 3, the byte in write-data bits 23:16 appears on `nand_io_out`. `nand_io_oe` is high only during such a write-type cycle, and never while `nand_re_n` is low.
- R4: CLE, ALE and the output byte are stable for one clock before `nand_we_n` falls and for one clock after it rises.
- R5: Each code 0, 1 or 3 write gives exactly one `nand_we_n` low pulse of `T_WP` clocks, then `T_WH` clocks of recovery before the acknowledge. The pulse starts one setup clock after acceptance.
- R6: Code 2 runs no flash cycle, is acknowledged in the next cycle and enters read mode. Codes 0, 1 and 3 leave read mode.
- R7: A register read in read mode gives exactly one `nand_re_n` low pulse of `T_RP` clocks, then `T_REH` recovery clocks. The byte on `nand_io_in` at the rising edge of `nand_re_n` is returned in read-data bits 23:16.
- R8: A register read outside read mode produces no `nand_re_n` strobe and is acknowledged in the next cycle.
- R9: On the acknowledge of a register read, bit 15 equals the inverse of `nand_rb_n`, and every other bit not named in R7 is zero. `host_rdata` is zero outside read acknowledges.
- R10: `host_ack` is a single-cycle pulse. A request is not accepted while a cycle runs or during its acknowledge cycle.
- R11: Codes 4 to 7 run no flash cycle and leave read mode unchanged. They only update the chip enable, and are acknowledged in the next cycle.
- R12: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high; CLE, ALE, `nand_io_oe` and `host_ack` are low; and read mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, held until acknowledge |
| host_we | input | 1 | 1 = register write, 0 = register read |
| host_wdata | input | 32 | Register write value |
| host_rdata | output | 32 | Register read value, valid with acknowledge |
| host_ack | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Flash data bus, outgoing value |
| nand_io_oe | output | 1 | Drive enable for the flash data bus |
| nand_io_in | input | 8 | Flash data bus, incoming value |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The assertions watch every cycle for the following:

- CLE and ALE never both high;
- the two strobes never low together, and the bus never driven while the read strobe is low;
- latch lines and bus frozen around each write-strobe edge;
- the write and read strobe widths, counted by a cycle counter;
- the single-cycle acknowledge;
- the next-cycle acknowledge for accesses that need no flash cycle.

The bench's cycle-level model covers what only whole sequences can show. That includes which byte returns on a read, that read mode is entered by code 2 and left by codes 0, 1 and 3, and that reads outside read mode and codes 4 to 7 leave both strobes idle. It also covers that the chip enable follows bit 31 of the last write, and that the busy bit tracks `nand_rb_n`.

// File: rtl/nand_bridge_pkg.sv
// Package: shared constants and state type for the NAND register bridge.
// Assumes a 32-bit register with MSB = bit 31.
package nand_bridge_pkg;
    localparam int REG_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int CE_BIT    = 31;
    localparam int OP_HI     = 30;
    localparam int OP_LO     = 28;
    localparam int BYTE_LO   = 16;
    localparam int BUSY_BIT  = 15;

    localparam logic [2:0] OP_CMD    = 3'd0;
    localparam logic [2:0] OP_ADDR   = 3'd1;
    localparam logic [2:0] OP_RDMODE = 3'd2;
    localparam logic [2:0] OP_WDATA  = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WLOW,
        ST_WHOLD,
        ST_RLOW,
        ST_RREC
    } seq_state_e;
endpackage

// File: rtl/nand_reg_decode.sv
// Module: nand_reg_decode
// Decodes host accesses to the bridge register into start requests for the
// pin sequencer. It holds the chip-enable flag and the read-mode flag.
// Assumes the host holds host_req until seq_ack is seen.
module nand_reg_decode
    import nand_bridge_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [REG_W-1:0]    host_wdata,
    input  logic                seq_idle,
    input  logic                seq_ack,
    output logic                start_wr,
    output logic                start_rd,
    output logic                start_none,
    output logic                wr_cle,
    output logic                wr_ale,
    output logic [BYTE_W-1:0]   wr_byte,
    output logic                ce_on,
    output logic                acc_read,
    output logic                acc_data
);
    logic       accept;
    logic [2:0] op;
    logic       op_is_wr;
    logic       rmode_q;

    assign accept   = host_req && seq_idle && !seq_ack;
    assign op       = host_wdata[OP_HI:OP_LO];
    assign op_is_wr = (op == OP_CMD) || (op == OP_ADDR) || (op == OP_WDATA);

    // Classify an accepted access into a write cycle, a read cycle or no cycle.
    always_comb begin
        start_wr   = accept && host_we && op_is_wr;
        start_rd   = accept && !host_we && rmode_q;
        start_none = accept && !(host_we && op_is_wr) && !(!host_we && rmode_q);
        wr_cle     = (op == OP_CMD);
        wr_ale     = (op == OP_ADDR);
        wr_byte    = host_wdata[BYTE_LO +: BYTE_W];
    end

    // Chip enable follows every write; read mode is set and cleared by op codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_on   <= 1'b0;
            rmode_q <= 1'b0;
        end else if (accept && host_we) begin
            ce_on <= host_wdata[CE_BIT];
            if (op == OP_RDMODE)
                rmode_q <= 1'b1;
            else if (op_is_wr)
                rmode_q <= 1'b0;
        end
    end

    // Remember the kind of the accepted access for read-data assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_read <= 1'b0;
            acc_data <= 1'b0;
        end else if (accept) begin
            acc_read <= !host_we;
            acc_data <= !host_we && rmode_q;
        end
    end

    // R6 / R11: mode-select and undefined codes finish in the next cycle.
    a_r6_no_cycle_ops: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && host_we && !op_is_wr) |=> (seq_idle && seq_ack));

    // R8: status read outside read mode finishes in the next cycle.
    a_r8_status_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !host_we && !rmode_q) |=> (seq_idle && seq_ack));
endmodule

// File: rtl/nand_pin_seq.sv
// Module: nand_pin_seq
// Drives the flash strobes for one write-type or read cycle. Timing:
// setup clock, WE# low T_WP, hold T_WH; or RE# low T_RP, recovery T_REH.
// It then raises a one-cycle acknowledge. Assumes every count is >= 2.
module nand_pin_seq
    import nand_bridge_pkg::*;
#(
    parameter int T_WP  = 3,
    parameter int T_WH  = 2,
    parameter int T_RP  = 4,
    parameter int T_REH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_wr,
    input  logic                start_rd,
    input  logic                start_none,
    input  logic                wr_cle,
    input  logic                wr_ale,
    input  logic [BYTE_W-1:0]   wr_byte,
    input  logic [BYTE_W-1:0]   nand_io_in,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_we_n,
    output logic                nand_re_n,
    output logic [BYTE_W-1:0]   nand_io_out,
    output logic                nand_io_oe,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic                seq_idle,
    output logic                seq_ack
);
    localparam int T_MAX_W = (T_WP > T_WH) ? T_WP : T_WH;
    localparam int T_MAX_R = (T_RP > T_REH) ? T_RP : T_REH;
    localparam int T_MAX   = (T_MAX_W > T_MAX_R) ? T_MAX_W : T_MAX_R;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    seq_state_e          state;
    logic [CNT_W-1:0]    cnt;
    logic                cle_q;
    logic                ale_q;
    logic [BYTE_W-1:0]   byte_q;
    logic                wr_phase;

    // Step through the strobe phases, count widths, capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            cle_q   <= 1'b0;
            ale_q   <= 1'b0;
            byte_q  <= '0;
            rd_byte <= '0;
            seq_ack <= 1'b0;
        end else begin
            seq_ack <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_wr) begin
                        state  <= ST_SETUP;
                        cle_q  <= wr_cle;
                        ale_q  <= wr_ale;
                        byte_q <= wr_byte;
                    end else if (start_rd) begin
                        state <= ST_RLOW;
                        cnt   <= CNT_W'(T_RP - 1);
                    end else if (start_none) begin
                        seq_ack <= 1'b1;
                    end
                end
                ST_SETUP: begin
                    state <= ST_WLOW;
                    cnt   <= CNT_W'(T_WP - 1);
                end
                ST_WLOW: begin
                    if (cnt == '0) begin
                        state <= ST_WHOLD;
                        cnt   <= CNT_W'(T_WH - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_WHOLD: begin
                    if (cnt == '0) begin
                        state   <= ST_IDLE;
                        seq_ack <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_RLOW: begin
                    if (cnt == '0) begin
                        state   <= ST_RREC;
                        rd_byte <= nand_io_in;
                        cnt     <= CNT_W'(T_REH - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_RREC: begin
                    if (cnt == '0) begin
                        state   <= ST_IDLE;
                        seq_ack <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the flash pins from the phase.
    always_comb begin
        wr_phase    = (state == ST_SETUP) || (state == ST_WLOW) || (state == ST_WHOLD);
        nand_cle    = wr_phase && cle_q;
        nand_ale    = wr_phase && ale_q;
        nand_io_oe  = wr_phase;
        nand_io_out = wr_phase ? byte_q : '0;
        nand_we_n   = (state != ST_WLOW);
        nand_re_n   = (state != ST_RLOW);
        seq_idle    = (state == ST_IDLE);
    end

    // Checker counters: consecutive low cycles of each strobe.
    logic [7:0] chk_wlo;
    logic [7:0] chk_rlo;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_wlo <= '0;
            chk_rlo <= '0;
        end else begin
            chk_wlo <= nand_we_n ? 8'd0 : chk_wlo + 8'd1;
            chk_rlo <= nand_re_n ? 8'd0 : chk_rlo + 8'd1;
        end
    end

    a_r1_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        nand_io_oe |-> (nand_re_n && seq_idle == 1'b0));

    a_r4_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale)
                              && $stable(nand_io_out) && nand_io_oe));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |=> ($stable(nand_cle) && $stable(nand_ale)
                              && $stable(nand_io_out) && nand_io_oe));

    a_r5_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (chk_wlo == 8'(T_WP)));

    a_r7_re_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_re_n) |-> (chk_rlo == 8'(T_RP)));

    a_r7_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        nand_we_n || nand_re_n);

    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_ack |=> !seq_ack);
endmodule

// File: rtl/nand_reg_bridge.sv
// Module: nand_reg_bridge (top)
// Single-register bridge from a host request/acknowledge bus to an 8-bit
// NAND flash. It joins the register decoder and the pin sequencer, and builds
// the read value from the captured byte and the busy flag.
// Assumes nand_rb_n is already synchronous to clk.
module nand_reg_bridge
    import nand_bridge_pkg::*;
#(
    parameter int T_WP  = 3,
    parameter int T_WH  = 2,
    parameter int T_RP  = 4,
    parameter int T_REH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               host_ack,
    output logic               nand_ce_n,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_we_n,
    output logic               nand_re_n,
    output logic [7:0]         nand_io_out,
    output logic               nand_io_oe,
    input  logic [7:0]         nand_io_in,
    input  logic               nand_rb_n
);
    logic              start_wr;
    logic              start_rd;
    logic              start_none;
    logic              wr_cle;
    logic              wr_ale;
    logic [BYTE_W-1:0] wr_byte;
    logic              ce_on;
    logic              acc_read;
    logic              acc_data;
    logic              seq_idle;
    logic              seq_ack;
    logic [BYTE_W-1:0] rd_byte;

    nand_reg_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .seq_idle   (seq_idle),
        .seq_ack    (seq_ack),
        .start_wr   (start_wr),
        .start_rd   (start_rd),
        .start_none (start_none),
        .wr_cle     (wr_cle),
        .wr_ale     (wr_ale),
        .wr_byte    (wr_byte),
        .ce_on      (ce_on),
        .acc_read   (acc_read),
        .acc_data   (acc_data)
    );

    nand_pin_seq #(
        .T_WP  (T_WP),
        .T_WH  (T_WH),
        .T_RP  (T_RP),
        .T_REH (T_REH)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (start_wr),
        .start_rd    (start_rd),
        .start_none  (start_none),
        .wr_cle      (wr_cle),
        .wr_ale      (wr_ale),
        .wr_byte     (wr_byte),
        .nand_io_in  (nand_io_in),
        .nand_cle    (nand_cle),
        .nand_ale    (nand_ale),
        .nand_we_n   (nand_we_n),
        .nand_re_n   (nand_re_n),
        .nand_io_out (nand_io_out),
        .nand_io_oe  (nand_io_oe),
        .rd_byte     (rd_byte),
        .seq_idle    (seq_idle),
        .seq_ack     (seq_ack)
    );

    assign nand_ce_n = ~ce_on;
    assign host_ack  = seq_ack;

    // Assemble the read value: busy flag and, in read mode, the captured byte.
    always_comb begin
        host_rdata = '0;
        if (seq_ack && acc_read) begin
            host_rdata[BUSY_BIT] = ~nand_rb_n;
            if (acc_data)
                host_rdata[BYTE_LO +: BYTE_W] = rd_byte;
        end
    end
endmodule

// File: tb/nand_reg_bridge_tb.sv
module nand_reg_bridge_tb;
    localparam int T_WP  = 3;
    localparam int T_WH  = 2;
    localparam int T_RP  = 4;
    localparam int T_REH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ack;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in = 8'h00;
    logic        nand_rb_n = 1'b1;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int we_falls = 0;
    int re_falls = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    nand_reg_bridge #(.T_WP(T_WP), .T_WH(T_WH), .T_RP(T_RP), .T_REH(T_REH)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Strobe edge counters.
    always @(negedge nand_we_n) if (rst_n) we_falls++;
    always @(negedge nand_re_n) if (rst_n) re_falls++;

    // Behavioural reference model, stepped on every rising edge.
    bit         m_busy, m_ack, m_pa, m_cle, m_ale, m_ce, m_rmode, m_isrd, m_isdata;
    int         m_kind, m_k;
    logic [7:0] m_byte, m_rbyte;
    logic [2:0] m_op;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_ack = 0; m_cle = 0; m_ale = 0; m_ce = 0; m_rmode = 0;
            m_isrd = 0; m_isdata = 0; m_kind = 0; m_k = 0; m_byte = 0; m_rbyte = 0;
        end else begin
            m_pa  = m_ack;
            m_ack = 0;
            if (m_busy) begin
                m_k++;
                if (m_kind == 1 && m_k == 1 + T_WP + T_WH) begin
                    m_busy = 0; m_ack = 1; m_isrd = 0; m_isdata = 0;
                end
                if (m_kind == 2) begin
                    if (m_k == T_RP) m_rbyte = nand_io_in;
                    if (m_k == T_RP + T_REH) begin
                        m_busy = 0; m_ack = 1; m_isrd = 1; m_isdata = 1;
                    end
                end
            end else if (host_req && !m_pa) begin
                m_op = host_wdata[30:28];
                if (host_we) begin
                    m_ce = host_wdata[31]; m_isrd = 0; m_isdata = 0;
                    if (m_op == 0 || m_op == 1 || m_op == 3) begin
                        m_busy = 1; m_kind = 1; m_k = 0;
                        m_cle = (m_op == 0); m_ale = (m_op == 1);
                        m_byte = host_wdata[23:16]; m_rmode = 0;
                    end else begin
                        if (m_op == 2) m_rmode = 1;
                        m_ack = 1;
                    end
                end else if (m_rmode) begin
                    m_busy = 1; m_kind = 2; m_k = 0;
                end else begin
                    m_ack = 1; m_isrd = 1; m_isdata = 0;
                end
            end
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            bit          e_wr;
            logic [31:0] e_rd;
            e_wr = m_busy && m_kind == 1;
            e_rd = '0;
            if (m_ack && m_isrd) begin
                e_rd[15] = ~nand_rb_n;
                if (m_isdata) e_rd[23:16] = m_rbyte;
            end
            chk(nand_cle === (e_wr && m_cle), "R1 R4", "cle", 32'(nand_cle), 32'(e_wr && m_cle));
            chk(nand_ale === (e_wr && m_ale), "R1 R4", "ale", 32'(nand_ale), 32'(e_wr && m_ale));
            chk(nand_ce_n === !m_ce, "R2", "ce_n", 32'(nand_ce_n), 32'(!m_ce));
            chk(nand_io_oe === e_wr, "R3", "io_oe", 32'(nand_io_oe), 32'(e_wr));
            chk(nand_io_out === (e_wr ? m_byte : 8'h00), "R3", "io_out",
                32'(nand_io_out), 32'(e_wr ? m_byte : 8'h00));
            chk(nand_we_n === !(e_wr && m_k >= 1 && m_k <= T_WP), "R5", "we_n",
                32'(nand_we_n), 32'(!(e_wr && m_k >= 1 && m_k <= T_WP)));
            chk(nand_re_n === !(m_busy && m_kind == 2 && m_k < T_RP), "R7", "re_n",
                32'(nand_re_n), 32'(!(m_busy && m_kind == 2 && m_k < T_RP)));
            chk(host_ack === m_ack, "R10", "ack", 32'(host_ack), 32'(m_ack));
            chk(host_rdata === e_rd, "R9", "rdata", host_rdata, e_rd);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // One host access; waits for the acknowledge and returns the read value.
    task automatic access(input bit we, input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_wdata = wd;
        forever begin
            @(negedge clk);
            if (host_ack) begin
                rd = host_rdata;
                host_req = 1'b0;
                break;
            end
        end
    endtask

    function automatic logic [31:0] wv(input bit ce, input logic [2:0] op, input logic [7:0] b);
        return {ce, op, 4'h0, b, 16'h0000};
    endfunction

    initial begin
        logic [31:0] rd;
        int wf, rf;
        repeat (3) @(negedge clk);
        // R12: reset state at the pins.
        chk(nand_ce_n === 1'b1, "R12", "reset ce_n", 32'(nand_ce_n), 1);
        chk(nand_we_n === 1'b1 && nand_re_n === 1'b1, "R12", "reset strobes",
            {nand_we_n, nand_re_n}, 2'b11);
        chk({nand_cle, nand_ale, nand_io_oe, host_ack} === 4'b0, "R12", "reset lines",
            {nand_cle, nand_ale, nand_io_oe, host_ack}, 0);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R8 R12: read right after reset is a status read with no strobe.
        rf = re_falls;
        access(0, 0, rd);
        chk(re_falls == rf, "R8 R12", "re strobes on status read", re_falls - rf, 0);
        chk(rd === 32'h0, "R9", "status ready", rd, 0);

        // R1 R5: command, address, address, command sequence.
        wf = we_falls;
        access(1, wv(1, 3'd0, 8'h00), rd);
        access(1, wv(1, 3'd1, 8'h12), rd);
        access(1, wv(1, 3'd1, 8'h34), rd);
        access(1, wv(1, 3'd0, 8'h30), rd);
        chk(we_falls - wf == 4, "R5", "one we strobe per write", we_falls - wf, 4);
        chk(nand_ce_n === 1'b0, "R2", "ce asserted", 32'(nand_ce_n), 0);

        // R9: busy bit while flash busy.
        nand_rb_n = 1'b0;
        access(0, 0, rd);
        chk(rd === 32'h0000_8000, "R9", "busy status", rd, 32'h0000_8000);
        nand_rb_n = 1'b1;

        // R6: enter read mode without a strobe.
        wf = we_falls; rf = re_falls;
        access(1, wv(1, 3'd2, 8'h00), rd);
        chk(we_falls == wf && re_falls == rf, "R6", "no strobe on mode select",
            (we_falls - wf) + (re_falls - rf), 0);

        // R7: reads in read mode strobe once and return the flash byte.
        nand_io_in = 8'hA5;
        access(0, 0, rd);
        chk(rd === 32'h00A5_0000, "R7", "read byte A5", rd, 32'h00A5_0000);
        nand_io_in = 8'h3C; nand_rb_n = 1'b0;
        access(0, 0, rd);
        chk(rd === 32'h003C_8000, "R7 R9", "read byte with busy", rd, 32'h003C_8000);
        nand_rb_n = 1'b1;
        chk(re_falls - rf == 2, "R7", "one re strobe per read", re_falls - rf, 2);

        // R11: undefined op keeps read mode, only clears chip enable.
        wf = we_falls;
        access(1, wv(0, 3'd5, 8'hFF), rd);
        chk(nand_ce_n === 1'b1 && we_falls == wf, "R11 R2", "op5 effect",
            {nand_ce_n, 8'(we_falls - wf)}, 9'h100);
        nand_io_in = 8'h81;
        rf = re_falls;
        access(0, 0, rd);
        chk(rd === 32'h0081_0000 && re_falls - rf == 1, "R11", "read mode kept", rd, 32'h0081_0000);

        // R3 R6: a data write leaves read mode; the following read only reports status.
        access(1, wv(1, 3'd3, 8'h5A), rd);
        access(1, wv(1, 3'd3, 8'hC3), rd);
        rf = re_falls;
        access(0, 0, rd);
        chk(re_falls == rf && rd === 32'h0, "R6 R8", "read mode left", rd, 0);

        // R10: back-to-back requests held high across the acknowledge.
        wf = we_falls;
        access(1, wv(1, 3'd1, 8'h77), rd);
        access(1, wv(1, 3'd1, 8'h78), rd);
        chk(we_falls - wf == 2, "R10", "two accesses two strobes", we_falls - wf, 2);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule